// File: doc/BRIEF.md
# Elapsed-Day Real-Time Clock

The block keeps wall time as four counters: seconds, minutes, hours in 24-hour form, and a count of whole days elapsed since a base date chosen by software. It has no calendar. Software turns the day count into a date. Time advances by one second for each pulse on the `tick` input, and only while the run bit is set. A prescaler upstream supplies that pulse.

Software sets the time by writing four write-only preload registers and then writing the control register with the load bit set. The copy into the live counters happens on that write, and the tick arriving in the same cycle is dropped. An hour/minute/second alarm compare, four sticky event flags and four one-cycle interrupt pulses report progress. All registers are 32-bit words behind a simple single-cycle register bus. Read data is combinational.

Register map (word offsets):

| Offset | Access | Contents |
|---|---|---|
| 0x00 / 0x04 / 0x08 / 0x0C | read-only | live second, minute, hour, day |
| 0x10 / 0x14 / 0x18 | read/write | alarm second, minute, hour |
| 0x1C | read/write | control |
| 0x20 / 0x24 / 0x28 / 0x2C | write-only | preload second, minute, hour, day |
| 0x30 | read / write-one-to-clear | status |

Top module: `daycount_rtc`

## Requirements
- R1: After reset all live counters, alarm registers, control and status read 0, and all four interrupt outputs are low.
- R2: The time advances by one second on a clock edge where `tick` is high and the run bit is set (control bit 0). With run clear, a tick changes nothing.
- R3: Seconds at 59 roll to 0 and advance minutes. Minutes at 59 roll to 0 and advance hours. For example, 9:59:59 becomes 10:00:00.
- R4: A tick at 23:59:59 gives 00:00:00 and adds one to the 16-bit day counter. The day counter wraps from 0xFFFF to 0 without any other effect.
- R5: Writing control (0x1C) with bit 1 set copies all four preloads into the live counters on that edge. A tick on the same edge is ignored. Bit 1 always reads back 0.
- R6: When a tick advances the time to a value whose hour, minute and second equal the alarm registers, status bit 0 sets.
- R7: Each advancing tick sets status bit 1. A seconds rollover sets status bit 2. A minutes rollover sets status bit 3.
- R8: Writing status (0x30) clears exactly the flags written as 1. An event in the same cycle wins over the clear.
- R9: Control bits 2, 3, 4 and 5 enable the interrupts for alarm, second, minute and hour. An interrupt output is a one-cycle pulse on the edge after its event, and fires only when its enable bit is set.
- R10: Writes to the unused offset 0x34, to offsets outside the window, and to the read-only live registers change no state.
- R11: The preload registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle once-per-second pulse |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_alarm | output | 1 | Alarm interrupt pulse |
| irq_sec | output | 1 | Second interrupt pulse |
| irq_min | output | 1 | Minute interrupt pulse |
| irq_hour | output | 1 | Hour interrupt pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit day counter and a 6-bit address. With a 16-bit day counter, the wrap from 0xFFFF to 0 is reached in a single preload and tick. Because preloading is possible, every rollover corner, including midnight at the last day, is reached in one tick instead of waiting through days of simulated time. Each table vector is a preload followed by one tick. Directed cases then cover load-versus-tick collision, alarm match, partial clearing, interrupt gating and stray writes.

// File: rtl/daycount_rtc.sv
module daycount_rtc #(
  parameter int DAY_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_alarm,
  output logic              irq_sec,
  output logic              irq_min,
  output logic              irq_hour
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] A_SEC  = IDX_W'(0);
  localparam logic [IDX_W-1:0] A_MIN  = IDX_W'(1);
  localparam logic [IDX_W-1:0] A_HOUR = IDX_W'(2);
  localparam logic [IDX_W-1:0] A_DAY  = IDX_W'(3);
  localparam logic [IDX_W-1:0] A_ASEC = IDX_W'(4);
  localparam logic [IDX_W-1:0] A_AMIN = IDX_W'(5);
  localparam logic [IDX_W-1:0] A_AHR  = IDX_W'(6);
  localparam logic [IDX_W-1:0] A_CTRL = IDX_W'(7);
  localparam logic [IDX_W-1:0] A_PSEC = IDX_W'(8);
  localparam logic [IDX_W-1:0] A_PMIN = IDX_W'(9);
  localparam logic [IDX_W-1:0] A_PHR  = IDX_W'(10);
  localparam logic [IDX_W-1:0] A_PDAY = IDX_W'(11);
  localparam logic [IDX_W-1:0] A_STAT = IDX_W'(12);

  logic [5:0]       sec_q, min_q, pre_sec, pre_min, al_sec, al_min;
  logic [4:0]       hour_q, pre_hour, al_hour;
  logic [DAY_W-1:0] day_q, pre_day;
  logic             run_q;
  logic [3:0]       ien_q, status_q, ev;

  wire [IDX_W-1:0] idx = bus_addr[ADDR_W-1:2];
  wire aligned  = (bus_addr[1:0] == 2'b00);
  wire wr       = bus_sel & bus_wr & aligned;
  wire wr_ctrl  = wr & (idx == A_CTRL);
  wire wr_stat  = wr & (idx == A_STAT);
  wire load_now = wr_ctrl & bus_wdata[1];
  wire adv      = run_q & tick & ~load_now;

  wire sec_roll  = (sec_q >= 6'd59);
  wire min_roll  = sec_roll & (min_q >= 6'd59);
  wire hour_roll = min_roll & (hour_q >= 5'd23);

  wire [5:0]       sec_n  = sec_roll ? 6'd0 : sec_q + 6'd1;
  wire [5:0]       min_n  = min_roll ? 6'd0 : (sec_roll ? min_q + 6'd1 : min_q);
  wire [4:0]       hour_n = hour_roll ? 5'd0 : (min_roll ? hour_q + 5'd1 : hour_q);
  wire [DAY_W-1:0] day_n  = hour_roll ? day_q + DAY_W'(1) : day_q;

  wire alarm_hit = adv & ({hour_n, min_n, sec_n} == {al_hour, al_min, al_sec});

  assign ev = {adv & min_roll, adv & sec_roll, adv, alarm_hit};

  wire unused_wdata = ^bus_wdata[31:DAY_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
      day_q  <= '0;
    end else if (load_now) begin
      sec_q  <= pre_sec;
      min_q  <= pre_min;
      hour_q <= pre_hour;
      day_q  <= pre_day;
    end else if (adv) begin
      sec_q  <= sec_n;
      min_q  <= min_n;
      hour_q <= hour_n;
      day_q  <= day_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_sec  <= '0;
      pre_min  <= '0;
      pre_hour <= '0;
      pre_day  <= '0;
      al_sec   <= '0;
      al_min   <= '0;
      al_hour  <= '0;
      run_q    <= 1'b0;
      ien_q    <= '0;
    end else if (wr) begin
      case (idx)
        A_PSEC: pre_sec  <= bus_wdata[5:0];
        A_PMIN: pre_min  <= bus_wdata[5:0];
        A_PHR:  pre_hour <= bus_wdata[4:0];
        A_PDAY: pre_day  <= bus_wdata[DAY_W-1:0];
        A_ASEC: al_sec   <= bus_wdata[5:0];
        A_AMIN: al_min   <= bus_wdata[5:0];
        A_AHR:  al_hour  <= bus_wdata[4:0];
        A_CTRL: begin
          run_q <= bus_wdata[0];
          ien_q <= bus_wdata[5:2];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      {irq_hour, irq_min, irq_sec, irq_alarm} <= '0;
    end else begin
      status_q <= (status_q & ~(wr_stat ? bus_wdata[3:0] : 4'b0)) | ev;
      {irq_hour, irq_min, irq_sec, irq_alarm} <= ev & ien_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (idx)
        A_SEC:  bus_rdata = 32'(sec_q);
        A_MIN:  bus_rdata = 32'(min_q);
        A_HOUR: bus_rdata = 32'(hour_q);
        A_DAY:  bus_rdata = 32'(day_q);
        A_ASEC: bus_rdata = 32'(al_sec);
        A_AMIN: bus_rdata = 32'(al_min);
        A_AHR:  bus_rdata = 32'(al_hour);
        A_CTRL: bus_rdata = 32'({ien_q, 1'b0, run_q});
        A_STAT: bus_rdata = 32'(status_q);
        default: bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/daycount_rtc_chk.sv
module daycount_rtc_chk #(
  parameter int DAY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             run_q,
  input logic             load_now,
  input logic [5:0]       sec_q,
  input logic [5:0]       min_q,
  input logic [4:0]       hour_q,
  input logic [DAY_W-1:0] day_q,
  input logic [5:0]       pre_sec,
  input logic [DAY_W-1:0] pre_day,
  input logic             irq_sec,
  input logic             irq_alarm
);

  // R2
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && run_q) && !load_now) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) && $stable(day_q)));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_q && !load_now && sec_q == 6'd59) |=> (sec_q == 6'd0));

  // R4
  day_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_q && !load_now && sec_q == 6'd59 && min_q == 6'd59 && hour_q == 5'd23)
    |=> (hour_q == 5'd0 && day_q == DAY_W'($past(day_q) + 1'b1)));

  // R5
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (sec_q == $past(pre_sec) && day_q == $past(pre_day)));

  // R9
  irq_sec_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sec |-> $past(tick && run_q && !load_now));

  // R9
  irq_alarm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_alarm |-> $past(tick && run_q && !load_now));

endmodule

bind daycount_rtc daycount_rtc_chk #(.DAY_W(DAY_W)) u_chk (.*);

// File: tb/daycount_rtc_bench.sv
module daycount_rtc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  // {pre_day, pre_h, pre_m, pre_s, exp_day, exp_h, exp_m, exp_s, exp_status}
  localparam logic [69:0] VEC [NV] = '{
    {16'd0,     5'd9,  6'd59, 6'd0,  16'd0,   5'd9,  6'd59, 6'd1,  4'b0010},
    {16'd0,     5'd9,  6'd59, 6'd59, 16'd0,   5'd10, 6'd0,  6'd0,  4'b1110},
    {16'd5,     5'd23, 6'd59, 6'd59, 16'd6,   5'd0,  6'd0,  6'd0,  4'b1111},
    {16'd0,     5'd12, 6'd30, 6'd59, 16'd0,   5'd12, 6'd31, 6'd0,  4'b0110},
    {16'hFFFF,  5'd23, 6'd59, 6'd59, 16'd0,   5'd0,  6'd0,  6'd0,  4'b1111},
    {16'd100,   5'd0,  6'd0,  6'd0,  16'd100, 5'd0,  6'd0,  6'd1,  4'b0010},
    {16'd3,     5'd14, 6'd15, 6'd9,  16'd3,   5'd14, 6'd15, 6'd10, 4'b0010}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_alarm, irq_sec, irq_min, irq_hour;
  int n_chk = 0, n_bad = 0;
  logic [31:0] r;
  logic [3:0] irqv;

  always #(CLK_PERIOD/2) clk = ~clk;

  daycount_rtc u_daycount_rtc (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(output logic [3:0] iv);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    iv = {irq_hour, irq_min, irq_sec, irq_alarm};
  endtask

  task automatic preload(input logic [15:0] d, input logic [4:0] h, input logic [5:0] m, input logic [5:0] s);
    wr(6'h20, 32'(s)); wr(6'h24, 32'(m)); wr(6'h28, 32'(h)); wr(6'h2C, 32'(d));
  endtask

  task automatic chk_time(input string req, input logic [15:0] d, input logic [4:0] h, input logic [5:0] m, input logic [5:0] s);
    rd(6'h00, r); chk(req, r, 32'(s));
    rd(6'h04, r); chk(req, r, 32'(m));
    rd(6'h08, r); chk(req, r, 32'(h));
    rd(6'h0C, r); chk(req, r, 32'(d));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_time("R1", 16'd0, 5'd0, 6'd0, 6'd0);
    rd(6'h1C, r); chk("R1", r, 32'd0);
    rd(6'h30, r); chk("R1", r, 32'd0);
    rd(6'h18, r); chk("R1", r, 32'd0);
    chk("R1", 32'({irq_hour, irq_min, irq_sec, irq_alarm}), 32'd0);

    // R3 R4 R6 R7 table walk
    for (int i = 0; i < NV; i++) begin
      logic [69:0] v;
      v = VEC[i];
      preload(v[69:54], v[53:49], v[48:43], v[42:37]);
      wr(6'h1C, 32'h3);
      wr(6'h30, 32'hF);
      pulse(irqv);
      chk_time("R3/R4 vector", v[36:21], v[20:16], v[15:10], v[9:4]);
      rd(6'h30, r); chk("R7 vector status", r, 32'(v[3:0]));
    end

    // R5 load bit reads 0, tick in load cycle dropped
    rd(6'h1C, r); chk("R5", r, 32'h1);
    preload(16'd7, 5'd8, 6'd9, 6'd10);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h1C; bus_wdata = 32'h3; tick = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick = 1'b0;
    chk_time("R5", 16'd7, 5'd8, 6'd9, 6'd10);

    // R11 preloads read 0
    rd(6'h20, r); chk("R11", r, 32'd0);
    rd(6'h2C, r); chk("R11", r, 32'd0);

    // R2 run clear blocks ticks
    wr(6'h1C, 32'h0);
    pulse(irqv);
    chk_time("R2", 16'd7, 5'd8, 6'd9, 6'd10);

    // R6 R9 alarm with interrupt enabled
    wr(6'h10, 32'd4); wr(6'h14, 32'd2); wr(6'h18, 32'd1);
    preload(16'd0, 5'd1, 6'd2, 6'd3);
    wr(6'h1C, 32'h7);
    wr(6'h30, 32'hF);
    pulse(irqv);
    chk("R9 alarm pulse", 32'(irqv), 32'b0001);
    @(negedge clk);
    chk("R9 single cycle", 32'(irq_alarm), 32'd0);
    rd(6'h30, r); chk("R6", r, 32'b0011);
    pulse(irqv);
    chk("R6 no rematch", 32'(irqv), 32'd0);

    // R9 second interrupt gated by enable
    wr(6'h1C, 32'h9);
    pulse(irqv);
    chk("R9 sec enabled", 32'(irqv), 32'b0010);
    wr(6'h1C, 32'h1);
    pulse(irqv);
    chk("R9 sec disabled", 32'(irqv), 32'd0);

    // R8 partial write-one-to-clear
    preload(16'd0, 5'd2, 6'd59, 6'd59);
    wr(6'h1C, 32'h3);
    wr(6'h30, 32'hF);
    pulse(irqv);
    wr(6'h30, 32'h4);
    rd(6'h30, r); chk("R8", r, 32'b1010);

    // R10 stray writes
    wr(6'h34, 32'hFFFF_FFFF);
    wr(6'h00, 32'd5);
    wr(6'h0C, 32'd9);
    wr(6'h3C, 32'hFFFF_FFFF);
    chk_time("R10", 16'd0, 5'd3, 6'd0, 6'd0);
    rd(6'h1C, r); chk("R10", r, 32'h1);
    rd(6'h30, r); chk("R10", r, 32'b1010);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule